// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block sits on the device side of a synchronous DRAM model. It produces the column address for every beat of one read or write burst. A one-cycle start pulse loads the starting column, the burst-length code and the ordering. From the next cycle the block steps through the burst, one column per clock. Each beat comes with a valid flag. Fixed-length bursts also raise a last-beat flag on their final beat.

Fixed bursts stay inside the block of columns aligned to their own length. Sequential ordering counts upward inside that block. Interleaved ordering XORs the beat index into the start column's low bits. The full-page length is legal only with sequential ordering: it walks the whole row and wraps from the top column back to zero, and it runs until something stops it. A terminate pulse ends any active burst. A new start replaces the running burst on any cycle.

Top module: `sdram_col_seq`

## Requirements
- R1: After reset, valid_o and last_o are low.
- R2: A start pulse sampled on a clock edge makes valid_o high and col_o equal to start_col_i from that edge on. This first beat is beat index 0.
- R3: The burst-length code sets the beat count. Code 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8. Code 7 selects full page. Codes 4, 5 and 6 give a single beat. A fixed burst keeps valid_o high for exactly its beat count, then drops it.
- R4: With sequential ordering (order_i = 0) and length L, beat k shows (start & ~(L-1)) | ((start + k) & (L-1)). The low log2(L) bits wrap inside the aligned block and the upper bits stay fixed.
- R5: With interleaved ordering (order_i = 1) and length L, beat k shows (start & ~(L-1)) | ((start ^ k) & (L-1)).
- R6: A full-page sequential burst shows (start + k) mod 2^COL_W on beat k, wrapping from 511 to 0 at default width. It never raises last_o and stays valid until it is terminated or restarted.
- R7: Full-page code 7 combined with interleaved ordering runs as a single-beat burst.
- R8: last_o is high only on the final beat of a fixed-length burst, and only while valid_o is high.
- R9: A terminate pulse sampled while a burst is valid clears valid_o at that same edge. A terminate pulse while idle has no effect. When start and terminate arrive together, the start wins.
- R10: A start pulse during an active burst restarts the sequence from its own column, length and ordering at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle read/write burst start |
| start_col_i | input | COL_W | Column given with the start |
| len_code_i | input | 3 | Burst-length code |
| order_i | input | 1 | 0 sequential, 1 interleaved |
| term_i | input | 1 | Burst terminate pulse |
| col_o | output | COL_W | Column of the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
Every result is due one clock edge after the stimulus that causes it. A start sampled at edge t shows beat 0 after edge t, and beat k appears k edges later. A terminate sampled at edge t lowers valid_o immediately after that edge. The valid flag falls at the edge that follows the last beat. The bench drives its inputs at falling edges and samples the outputs at the next falling edge, so each check reads the value that exactly one rising edge has produced.

// File: rtl/col_seq_pkg.sv
package col_seq_pkg;

   localparam logic [2:0] LEN_1    = 3'd0;
   localparam logic [2:0] LEN_2    = 3'd1;
   localparam logic [2:0] LEN_4    = 3'd2;
   localparam logic [2:0] LEN_8    = 3'd3;
   localparam logic [2:0] LEN_PAGE = 3'd7;

   typedef enum logic {
      ORD_SEQ   = 1'b0,
      ORD_INTLV = 1'b1
   } order_e;

   // Decoded burst shape: page = open-ended full row, lg = log2 of fixed beat count
   typedef struct packed {
      logic       page;
      logic [1:0] lg;
      order_e     ord;
   } burst_cfg_t;

endpackage

// File: rtl/burst_decode.sv
module burst_decode
   import col_seq_pkg::*;
#(
   parameter bit INTLV_EN = 1'b1
) (
   input  logic [2:0] len_code_i,
   input  logic       order_i,
   output burst_cfg_t cfg_o
);

   logic   code_fixed;
   order_e ord_eff;

   assign code_fixed = (len_code_i[2] == 1'b0);

   generate
      if (INTLV_EN) begin : g_intlv
         assign ord_eff = order_e'(order_i);
      end else begin : g_seq_only
         assign ord_eff = ORD_SEQ;
      end
   endgenerate

   always_comb begin
      cfg_o.ord  = ord_eff;
      cfg_o.page = 1'b0;
      cfg_o.lg   = 2'd0;
      if (code_fixed) begin
         cfg_o.lg = len_code_i[1:0];
      end else if (len_code_i == LEN_PAGE && ord_eff == ORD_SEQ) begin
         cfg_o.page = 1'b1;
      end
      // reserved codes and page+interleave fall through to one beat
   end

endmodule

// File: rtl/col_gen.sv
module col_gen
   import col_seq_pkg::*;
#(
   parameter int COL_W = 9
) (
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] cnt_i,
   input  burst_cfg_t       cfg_i,
   output logic [COL_W-1:0] mask_o,
   output logic [COL_W-1:0] col_o
);

   logic [COL_W-1:0] low_bits;

   generate
      for (genvar i = 0; i < COL_W; i++) begin : g_mask
         assign mask_o[i] = cfg_i.page | (i < (1 << cfg_i.lg) - 1 + 0 ? (i < 32'(cfg_i.lg)) : 1'b0);
      end
   endgenerate

   always_comb begin
      if (cfg_i.ord == ORD_INTLV) low_bits = base_i ^ cnt_i;
      else                        low_bits = base_i + cnt_i;
      col_o = (base_i & ~mask_o) | (low_bits & mask_o);
   end

endmodule

// File: rtl/beat_ctrl.sv
module beat_ctrl #(
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             term_i,
   input  logic             final_i,
   output logic             valid_o,
   output logic [COL_W-1:0] cnt_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         cnt_o   <= '0;
      end else if (start_i) begin
         valid_o <= 1'b1;
         cnt_o   <= '0;
      end else if (valid_o && (term_i || final_i)) begin
         valid_o <= 1'b0;
         cnt_o   <= '0;
      end else if (valid_o) begin
         cnt_o   <= cnt_o + 1'b1;
      end
   end

endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
   import col_seq_pkg::*;
#(
   parameter int COL_W    = 9,
   parameter bit INTLV_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [2:0]       len_code_i,
   input  logic             order_i,
   input  logic             term_i,
   output logic [COL_W-1:0] col_o,
   output logic             valid_o,
   output logic             last_o
);

   localparam int MAX_FIXED = 8;
   localparam int FIXED_LG  = $clog2(MAX_FIXED);

   generate
      if (COL_W < FIXED_LG + 1) begin : g_bad_width
         $error("sdram_col_seq: COL_W must hold an aligned 8-beat block");
      end
   endgenerate

   burst_cfg_t       cfg_new, cfg_q;
   logic [COL_W-1:0] base_q;
   logic [COL_W-1:0] cnt;
   logic [COL_W-1:0] blk_mask;
   logic             final_beat;

   burst_decode #(.INTLV_EN(INTLV_EN)) u_dec (
      .len_code_i (len_code_i),
      .order_i    (order_i),
      .cfg_o      (cfg_new)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         cfg_q  <= '0;
      end else if (start_i) begin
         base_q <= start_col_i;
         cfg_q  <= cfg_new;
      end
   end

   beat_ctrl #(.COL_W(COL_W)) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .term_i  (term_i),
      .final_i (final_beat),
      .valid_o (valid_o),
      .cnt_o   (cnt)
   );

   col_gen #(.COL_W(COL_W)) u_gen (
      .base_i (base_q),
      .cnt_i  (cnt),
      .cfg_i  (cfg_q),
      .mask_o (blk_mask),
      .col_o  (col_o)
   );

   assign final_beat = ~cfg_q.page & (cnt == blk_mask);
   assign last_o     = valid_o & final_beat;

endmodule

// File: rtl/sdram_col_seq_chk.sv
module sdram_col_seq_chk #(
   parameter int COL_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [COL_W-1:0] start_col_i,
   input logic             term_i,
   input logic [COL_W-1:0] col_o,
   input logic             valid_o,
   input logic             last_o,
   input logic [COL_W-1:0] blk_mask
);

   // R2 / R10: a start always yields its own column as beat 0
   a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (valid_o && col_o == $past(start_col_i)));

   // R9: terminate on an active burst ends it
   a_r9_term_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && term_i && !start_i) |=> !valid_o);

   // R8: final beat is followed by idle unless restarted
   a_r8_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !start_i) |=> !valid_o);

   // R8: last only accompanies a valid beat
   a_r8_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o);

   // R4: bits outside the burst block stay fixed between beats
   a_r4_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !last_o && !term_i && !start_i) |=>
         (valid_o && ((col_o ^ $past(col_o)) & ~$past(blk_mask)) == '0));

   // R1: idle holds while nothing starts
   a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_o && !start_i) |=> !valid_o);

endmodule

bind sdram_col_seq sdram_col_seq_chk #(.COL_W(COL_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .start_col_i (start_col_i),
   .term_i      (term_i),
   .col_o       (col_o),
   .valid_o     (valid_o),
   .last_o      (last_o),
   .blk_mask    (blk_mask)
);

// File: tb/tb_sdram_col_seq.sv
module tb_sdram_col_seq;

   localparam int COL_W = 9;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [COL_W-1:0] start_col_i = '0;
   logic [2:0]       len_code_i = '0;
   logic             order_i = 1'b0;
   logic             term_i = 1'b0;
   logic [COL_W-1:0] col_o;
   logic             valid_o;
   logic             last_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sdram_col_seq #(.COL_W(COL_W)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
      .len_code_i(len_code_i), .order_i(order_i), .term_i(term_i),
      .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // beats per code per R3/R7; 0 means full page
   function automatic int beats(input logic [2:0] code, input logic ord);
      if (code <= 3'd3) return 1 << code;
      if (code == 3'd7 && ord == 1'b0) return 0;
      return 1;
   endfunction

   function automatic int exp_col(input int base, input int k, input int len, input logic ord);
      int m;
      if (len == 0) return (base + k) % (1 << COL_W);
      m = len - 1;
      if (ord) return (base & ~m) | ((base ^ k) & m);
      return (base & ~m) | ((base + k) & m);
   endfunction

   task automatic do_start(input int col, input logic [2:0] code, input logic ord);
      start_i = 1'b1; start_col_i = COL_W'(col); len_code_i = code; order_i = ord;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   // Fixed burst: checks every beat, last flag and the drop afterwards
   task automatic t_fixed(input int col, input logic [2:0] code, input logic ord, input string req);
      int len;
      len = beats(code, ord);
      do_start(col, code, ord);
      for (int k = 0; k < len; k++) begin
         check(valid_o == 1'b1, req, int'(valid_o), 1);
         check(int'(col_o) == exp_col(col, k, len, ord), req, int'(col_o), exp_col(col, k, len, ord));
         check(last_o == (k == len - 1), "R8", int'(last_o), int'(k == len - 1));
         @(negedge clk);
      end
      check(valid_o == 1'b0, "R3", int'(valid_o), 0);
      @(negedge clk);
   endtask

   task automatic t_reset();
      check(valid_o == 1'b0, "R1", int'(valid_o), 0);
      check(last_o == 1'b0, "R1", int'(last_o), 0);
   endtask

   task automatic t_full_page();
      do_start(508, 3'd7, 1'b0);
      for (int k = 0; k < 8; k++) begin
         check(int'(col_o) == exp_col(508, k, 0, 1'b0), "R6", int'(col_o), exp_col(508, k, 0, 1'b0));
         check(valid_o && !last_o, "R6", int'(last_o), 0);
         @(negedge clk);
      end
      term_i = 1'b1;
      @(negedge clk);
      term_i = 1'b0;
      check(valid_o == 1'b0, "R9", int'(valid_o), 0);
      @(negedge clk);
   endtask

   task automatic t_term_idle();
      term_i = 1'b1;
      @(negedge clk);
      term_i = 1'b0;
      check(valid_o == 1'b0, "R9", int'(valid_o), 0);
      // a burst after an idle terminate runs to full length
      t_fixed(33, 3'd1, 1'b0, "R9");
   endtask

   task automatic t_term_mid();
      do_start(40, 3'd3, 1'b0);
      @(negedge clk);
      term_i = 1'b1;
      @(negedge clk);
      term_i = 1'b0;
      check(valid_o == 1'b0, "R9", int'(valid_o), 0);
      @(negedge clk);
   endtask

   task automatic t_start_beats_term();
      do_start(70, 3'd3, 1'b0);
      term_i = 1'b1;
      do_start(200, 3'd2, 1'b1);
      term_i = 1'b0;
      check(valid_o == 1'b1, "R9", int'(valid_o), 1);
      check(int'(col_o) == 200, "R9", int'(col_o), 200);
      for (int k = 0; k < 4; k++) @(negedge clk);
      check(valid_o == 1'b0, "R9", int'(valid_o), 0);
   endtask

   task automatic t_restart();
      do_start(10, 3'd3, 1'b0);
      @(negedge clk);
      @(negedge clk);
      check(int'(col_o) == 12, "R10", int'(col_o), 12);
      do_start(101, 3'd2, 1'b1);
      for (int k = 0; k < 4; k++) begin
         check(int'(col_o) == exp_col(101, k, 4, 1'b1), "R10", int'(col_o), exp_col(101, k, 4, 1'b1));
         check(last_o == (k == 3), "R10", int'(last_o), int'(k == 3));
         @(negedge clk);
      end
      check(valid_o == 1'b0, "R10", int'(valid_o), 0);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fixed(5, 3'd0, 1'b0, "R2");
      t_fixed(6, 3'd1, 1'b0, "R4");
      t_fixed(22, 3'd2, 1'b0, "R4");
      t_fixed(301, 3'd3, 1'b0, "R4");
      t_fixed(13, 3'd2, 1'b1, "R5");
      t_fixed(146, 3'd3, 1'b1, "R5");
      t_fixed(3, 3'd1, 1'b1, "R5");
      t_fixed(77, 3'd5, 1'b0, "R3");
      t_fixed(88, 3'd7, 1'b1, "R7");
      t_full_page();
      t_term_mid();
      t_term_idle();
      t_start_beats_term();
      t_restart();
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual 0 expected 1");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule